// File: doc/BRIEF.md
# Run-Length Infrared FIFO Transceiver

This block sits between a consumer infrared front end and a byte-wide register bus. On the receive side it samples the infrared line once per sample unit. It turns each stretch of constant level into a one-byte run code and stores the codes in a 16-entry receive FIFO. On the transmit side it takes run codes from a 16-entry transmit FIFO and replays them on the infrared output, one sample unit per count. The bus sees two FIFO windows, four interrupt sources with an enable mask, a line status register and an auxiliary control register.

A run code holds a level flag in bit 7 and a count X in bits 6:0. It stands for X+1 sample units. The sample unit is 16 core clocks multiplied by the divisor input. With a 24 MHz clock, a divisor of 15 gives 10 us and a divisor of 3 gives 2 us. Software arms end-of-transmission before it writes the final code, so the transmitter stops cleanly instead of reporting an underrun. The receiver can be told to go idle. It then ignores the line until the next pulse arrives.

The bus has no back-pressure. A write or read strobe is a single cycle and is always accepted. Read data is registered and appears one cycle after the strobe. A write to a full transmit FIFO is dropped. A data read from an empty receive FIFO returns zero and changes nothing.

Top module: `ir_rl_xcvr`

## Requirements
- R1: Run code layout, shared by both directions: bit 7 = 1 means space (line low) and 0 means pulse (line high). Bits 6:0 hold X. On `ir_tx` and `ir_rx`, 1 is the pulse level.
- R2: A code lasts X+1 sample units. One sample unit is 16×`divisor` clocks, and a divisor of 0 is taken as 1.
- R3: The receiver emits a code when the sampled level changes. A run that has reached 128 units is emitted as X=127 when the next same-level sample arrives, and counting restarts at that sample.
- R4: The receive FIFO holds 16 codes. A code that arrives while it is full is dropped and sets the overrun flag (line status bit 1). Reading line status clears that flag, unless a new drop happens in the same cycle.
- R5: Line status bit 0 is 1 while the receive FIFO holds at least one code. Register addresses: 0 = FIFO data (a read pops the receive FIFO, a write pushes the transmit FIFO), 1 = interrupt enable, 2 = interrupt identification, 3 = line status, 4 = auxiliary.
- R6: Auxiliary bit 5 forces the receiver idle, and it is set at reset. While idle, samples are discarded until the first pulse sample. That sample starts a pulse run and clears the bit.
- R7: The transmitter plays codes in the order they were written. The output is 0 whenever nothing is playing.
- R8: Writing 1 to auxiliary bit 2 arms end-of-transmission. When a code ends with the FIFO empty and the flag armed, the transmitter stops, the flag clears and no underrun is raised.
- R9: When a code ends with the FIFO empty and end-of-transmission not armed, auxiliary bit 6 (underrun) is set and the output goes to 0. Writing 1 to bit 6 clears it.
- R10: Identification equals the sources ANDed with the enable mask, and `irq` is the OR of identification. The sources are: 0x01 = receive FIFO holds 8 or more codes, 0x02 = transmit FIFO holds 3 or fewer codes, 0x04 = overrun or underrun flag set, 0x20 = transmit FIFO empty and transmitter stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd` |
| divisor | input | 16 | Sample unit divisor |
| ir_rx | input | 1 | Infrared receive line, 1 = pulse |
| ir_tx | output | 1 | Infrared transmit line, 1 = pulse |
| irq | output | 1 | Interrupt request |

## Verification
If a run counter goes wrong, a code read back from the receive FIFO shows the error one code later, and a transmit counter error shows at once as a pulse of the wrong width on `ir_tx`. If the transmitter busy state gets stuck, no run follows on `ir_tx`, or an underrun appears within one sample unit of the FIFO running dry. Overrun and FIFO count faults show at the next line status read. A receiver that mishandles forced idle either emits codes while idle or keeps auxiliary bit 5 set after a pulse. The bench loops `ir_tx` back to `ir_rx`, so run codes make a round trip with exact unit alignment.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_IDENT = 3'd2;
  localparam logic [2:0] A_LSTAT = 3'd3;
  localparam logic [2:0] A_AUX   = 3'd4;

  localparam int B_IRQ_RX      = 0;
  localparam int B_IRQ_TXLOW   = 1;
  localparam int B_IRQ_ERR     = 2;
  localparam int B_IRQ_TXEMPTY = 5;

  localparam int B_LS_AVAIL = 0;
  localparam int B_LS_OVR   = 1;

  localparam int B_AUX_EOT  = 2;
  localparam int B_AUX_IDLE = 5;
  localparam int B_AUX_UNDR = 6;

  localparam int RUN_W  = 7;
  localparam int CODE_W = RUN_W + 1;
endpackage

// File: rtl/ir_rl_fifo.sv
module ir_rl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/ir_rl_rx.sv
module ir_rl_rx
  import ir_rl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sample,
  input  logic              force_idle,
  output logic              idle,
  output logic              emit,
  output logic [CODE_W-1:0] code
);
  logic             lvl;
  logic [RUN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle <= 1'b1;
      lvl  <= 1'b0;
      cnt  <= '0;
      emit <= 1'b0;
      code <= '0;
    end else begin
      emit <= 1'b0;
      if (force_idle) begin
        idle <= 1'b1;
      end else if (tick) begin
        if (idle) begin
          if (sample) begin
            idle <= 1'b0;
            lvl  <= 1'b1;
            cnt  <= '0;
          end
        end else if (sample != lvl) begin
          emit <= 1'b1;
          code <= {~lvl, cnt};
          lvl  <= sample;
          cnt  <= '0;
        end else if (cnt == '1) begin
          emit <= 1'b1;
          code <= {~lvl, cnt};
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_rl_tx.sv
module ir_rl_tx
  import ir_rl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              avail,
  input  logic [CODE_W-1:0] head,
  input  logic              eot_armed,
  output logic              pop,
  output logic              busy,
  output logic              line,
  output logic              eot_done,
  output logic              underrun
);
  logic [RUN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      line     <= 1'b0;
      cnt      <= '0;
      pop      <= 1'b0;
      eot_done <= 1'b0;
      underrun <= 1'b0;
    end else begin
      pop      <= 1'b0;
      eot_done <= 1'b0;
      underrun <= 1'b0;
      if (tick) begin
        if (busy && cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (avail) begin
          pop  <= 1'b1;
          busy <= 1'b1;
          line <= ~head[CODE_W-1];
          cnt  <= head[RUN_W-1:0];
        end else if (busy) begin
          busy <= 1'b0;
          line <= 1'b0;
          if (eot_armed) eot_done <= 1'b1;
          else           underrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_rl_xcvr.sv
module ir_rl_xcvr
  import ir_rl_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DIV_W        = 16,
  parameter int RX_IRQ_LEVEL = 8,
  parameter int TX_LOW_LEVEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [DIV_W-1:0] divisor,
  input  logic             ir_rx,
  output logic             ir_tx,
  output logic             irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = DIV_W + 4;

  // sample-unit prescaler
  logic [PW-1:0] pcnt, plim;
  logic          tick;
  assign plim = (divisor == '0) ? PW'(15) : {divisor, 4'b0000} - 1'b1;
  assign tick = (pcnt >= plim);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  // input synchronizer
  logic [1:0] rx_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sync <= '0;
    else        rx_sync <= {rx_sync[0], ir_rx};
  end

  logic              wr_data, wr_aux, rd_data, rd_stat;
  assign wr_data = wr && addr == A_DATA;
  assign wr_aux  = wr && addr == A_AUX;
  assign rd_data = rd && addr == A_DATA;
  assign rd_stat = rd && addr == A_LSTAT;

  // receive path
  logic              rx_idle, rx_emit;
  logic [CODE_W-1:0] rx_code, rx_head;
  logic              rx_full, rx_empty;
  logic [CW-1:0]     rx_count;

  ir_rl_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample(rx_sync[1]),
    .force_idle(wr_aux && wdata[B_AUX_IDLE]),
    .idle(rx_idle), .emit(rx_emit), .code(rx_code)
  );

  ir_rl_fifo #(.W(CODE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_emit), .din(rx_code),
    .pop(rd_data), .dout(rx_head), .full(rx_full), .empty(rx_empty),
    .count(rx_count)
  );

  // transmit path
  logic              tx_pop, tx_busy, tx_eot_done, tx_undr;
  logic [CODE_W-1:0] tx_head;
  logic              tx_full, tx_empty;
  logic [CW-1:0]     tx_count;
  logic              eot_q, underrun_q, overrun_q;
  logic [7:0]        ien;

  ir_rl_fifo #(.W(CODE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .din(wdata),
    .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_count)
  );

  ir_rl_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(!tx_empty),
    .head(tx_head), .eot_armed(eot_q), .pop(tx_pop), .busy(tx_busy),
    .line(ir_tx), .eot_done(tx_eot_done), .underrun(tx_undr)
  );

  // flags and interrupt identification
  logic [7:0] src, ident;
  always_comb begin
    src                = '0;
    src[B_IRQ_RX]      = (rx_count >= CW'(RX_IRQ_LEVEL));
    src[B_IRQ_TXLOW]   = (tx_count <= CW'(TX_LOW_LEVEL));
    src[B_IRQ_ERR]     = overrun_q || underrun_q;
    src[B_IRQ_TXEMPTY] = tx_empty && !tx_busy;
  end
  assign ident = src & ien;
  assign irq   = |ident;

  logic [7:0] ien_mask;
  assign ien_mask = 8'(1 << B_IRQ_RX) | 8'(1 << B_IRQ_TXLOW) |
                    8'(1 << B_IRQ_ERR) | 8'(1 << B_IRQ_TXEMPTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien        <= '0;
      eot_q      <= 1'b0;
      underrun_q <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      if (wr && addr == A_IEN) ien <= wdata & ien_mask;

      if (wr_aux && wdata[B_AUX_EOT]) eot_q <= 1'b1;
      else if (tx_eot_done)           eot_q <= 1'b0;

      if (tx_undr)                          underrun_q <= 1'b1;
      else if (wr_aux && wdata[B_AUX_UNDR]) underrun_q <= 1'b0;

      if (rx_emit && rx_full) overrun_q <= 1'b1;
      else if (rd_stat)       overrun_q <= 1'b0;
    end
  end

  // registered read port
  logic [7:0] lstat, aux;
  always_comb begin
    lstat             = '0;
    lstat[B_LS_AVAIL] = !rx_empty;
    lstat[B_LS_OVR]   = overrun_q;
    aux               = '0;
    aux[B_AUX_EOT]    = eot_q;
    aux[B_AUX_IDLE]   = rx_idle;
    aux[B_AUX_UNDR]   = underrun_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        A_DATA:  rdata <= rx_empty ? 8'h00 : rx_head;
        A_IEN:   rdata <= ien;
        A_IDENT: rdata <= ident;
        A_LSTAT: rdata <= lstat;
        A_AUX:   rdata <= aux;
        default: rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/ir_rl_xcvr_chk.sv
module ir_rl_xcvr_chk
  import ir_rl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ir_tx,
  input logic          irq,
  input logic          tx_busy,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic [7:0]    ien,
  input logic          overrun_q,
  input logic          underrun_q,
  input logic          rd,
  input logic [2:0]    addr
);
  // R4: neither queue ever holds more than its depth
  p_fifo_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH) && tx_count <= CW'(DEPTH));

  // R4: overrun stays set until line status is read
  p_overrun_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q && !(rd && addr == A_LSTAT) |=> overrun_q);

  // R7: output is at space level whenever nothing is playing
  p_idle_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !ir_tx);

  // R9: a fresh underrun leaves the output at space level
  p_underrun_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_q) |-> !ir_tx);

  // R10: enabled receive-level and empty sources raise the request
  p_rx_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[B_IRQ_RX] && rx_count >= CW'(8)) |-> irq);

  p_txempty_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[B_IRQ_TXEMPTY] && tx_count == '0 && !tx_busy) |-> irq);
endmodule

bind ir_rl_xcvr ir_rl_xcvr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_tx(ir_tx), .irq(irq), .tx_busy(tx_busy),
  .tx_count(tx_count), .rx_count(rx_count), .ien(ien),
  .overrun_q(overrun_q), .underrun_q(underrun_q), .rd(rd), .addr(addr)
);

// File: tb/ir_rl_xcvr_test.sv
module ir_rl_xcvr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] divisor = 16'd1;
  logic        loop_en = 1'b0, rx_drive = 1'b0;
  logic        ir_rx, ir_tx, irq;
  int          checks = 0, errors = 0;
  int          unit = 16;

  always #10 clk = ~clk;  // 50 MHz

  assign ir_rx = loop_en ? ir_tx : rx_drive;

  ir_rl_xcvr uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .divisor(divisor), .ir_rx(ir_rx), .ir_tx(ir_tx), .irq(irq)
  );

  // {code written to transmit, code expected back from receive}
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    16'h0404, 16'h8989, 16'h0202, 16'hC0C0, 16'h0000, 16'h8585, 16'h7F7F
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_units(input int n);
    repeat (n * unit) @(negedge clk);
  endtask

  task automatic drain();
    logic [7:0] s, d;
    for (int i = 0; i < 20; i++) begin
      reg_rd(3'd3, s);
      if (s[0]) reg_rd(3'd0, d);
    end
  endtask

  initial begin
    logic [7:0] v, d;
    int hi, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(3'd3, v); check("R5 reset status", v, 8'h00);
    reg_rd(3'd4, v); check("R6 reset aux idle", v, 8'h20);
    check("R7 reset ir_tx", ir_tx, 0);
    check("R10 reset irq", irq, 0);

    // loopback round trip through the vector table
    loop_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (i == NV - 1) reg_wr(3'd4, 8'h04);
      reg_wr(3'd0, VEC[i][15:8]);
    end
    wait_units(240);
    loop_en = 1'b0; rx_drive = 1'b0;
    for (int i = 0; i < NV; i++) begin
      reg_rd(3'd0, v);
      check($sformatf("R1 R2 R3 R7 loopback code %0d", i), v, VEC[i][7:0]);
    end
    reg_rd(3'd4, v); check("R8 R6 aux after eot", v, 8'h00);
    reg_wr(3'd1, 8'h20);
    reg_rd(3'd2, v); check("R10 tx empty ident", v, 8'h20);
    check("R10 irq on tx empty", irq, 1);

    // pulse width at divisor 3
    divisor = 16'd3; unit = 48;
    reg_wr(3'd1, 8'h00);
    reg_wr(3'd4, 8'h04);
    reg_wr(3'd0, 8'h09);
    hi = 0; n = 0;
    while (n < 2000 && !(hi > 0 && !ir_tx)) begin
      @(negedge clk); n++;
      if (ir_tx) hi++;
    end
    check("R2 pulse width at divisor 3", hi, 480);
    reg_rd(3'd4, v); check("R8 no underrun with eot", v, 8'h00);
    divisor = 16'd1; unit = 16;

    // underrun
    reg_wr(3'd1, 8'h04);
    reg_wr(3'd0, 8'h03);
    wait_units(10);
    reg_rd(3'd4, v); check("R9 underrun set", v, 8'h40);
    check("R9 output at space", ir_tx, 0);
    reg_rd(3'd2, v); check("R10 error ident", v, 8'h04);
    reg_wr(3'd4, 8'h40);
    reg_rd(3'd4, v); check("R9 underrun cleared", v, 8'h00);
    check("R10 irq drops", irq, 0);

    // transmit low level
    reg_wr(3'd1, 8'h02);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) reg_wr(3'd4, 8'h04);
      reg_wr(3'd0, (i % 2) ? 8'hFF : 8'h7F);
    end
    reg_rd(3'd2, v); check("R10 tx low clear when filled", v, 8'h00);
    wait_units(300);
    reg_rd(3'd2, v); check("R10 tx low at three", v, 8'h02);
    wait_units(520);
    reg_rd(3'd4, v); check("R8 long burst ends cleanly", v, 8'h00);

    // forced idle
    rx_drive = 1'b0;
    reg_wr(3'd4, 8'h20);
    drain();
    wait_units(20);
    reg_rd(3'd4, v); check("R6 idle holds on space", v, 8'h20);
    reg_rd(3'd3, v); check("R6 nothing emitted while idle", v, 8'h00);
    rx_drive = 1'b1;
    wait_units(5);
    reg_rd(3'd4, v); check("R6 idle cleared by pulse", v, 8'h00);

    // overflow
    reg_wr(3'd1, 8'h01);
    for (int i = 0; i < 24; i++) begin
      rx_drive = ~rx_drive;
      wait_units(3);
    end
    reg_rd(3'd2, v); check("R10 rx level ident", v, 8'h01);
    reg_rd(3'd3, v); check("R4 R5 overrun and avail", v, 8'h03);
    reg_rd(3'd3, v); check("R4 overrun cleared by read", v, 8'h01);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      reg_rd(3'd3, v);
      if (v[0]) begin
        reg_rd(3'd0, d);
        if (n == 0) check("R1 first code is pulse", d[7], 0);
        if (n == 1) check("R1 second code is space", d[7], 1);
        n++;
      end
    end
    check("R4 queue held sixteen", n, 16);

    // long run splitting
    rx_drive = 1'b0;
    reg_wr(3'd4, 8'h20);
    wait_units(5);
    drain();
    rx_drive = 1'b1;
    wait_units(10);
    rx_drive = 1'b0;
    wait_units(140);
    reg_rd(3'd0, v); check("R3 pulse before long space", v[7], 0);
    reg_rd(3'd0, v); check("R3 split at 128 units", v, 8'hFF);
    reg_rd(3'd3, v); check("R3 R5 remainder pending", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule